// File: doc/BRIEF.md
# Output-Enable Control Slave on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C, standard mode) at the fixed 7-bit address 1101001. It keeps a small bank of 8-bit enable registers and turns selected bits of them into 13 per-output enable lines for a clock fanout stage. SCL and SDA are oversampled by the system clock. Each line passes through a two-flop synchroniser and a stability filter. START, STOP and SCL edges are derived from the filtered levels. SDA is driven open-drain: the single output asks the pad to pull the line low.

A write frame is the address byte 0xD2 followed by a command byte and a byte-count byte. The block acknowledges both of these and drops them. The data bytes that follow land in register 0, then 1, then 2. A read frame is the address byte 0xD3. The block then returns a byte-count value of 0x09, followed by the registers in ascending order. There is no register addressing: every frame starts again at the lowest byte. A START or STOP anywhere restarts the byte sequence. The block has no streaming data path, so there is no valid/ready pair; every pin is a plain level.

Top module: `fanout_en_i2c_slave`

## Requirements
- R1: After reset all 13 enable outputs are 1, SDA is released (`sda_pull_o`=0), and every register reads back 0xFF.
- R2: The block acknowledges (pulls SDA low in the ninth clock) only the address bytes 0xD2 (write) and 0xD3 (read). Any other address is not acknowledged, and the rest of that frame changes no register.
- R3: In a write frame the first two bytes after the address are acknowledged and do not change any register or output.
- R4: From the third byte after the address onward, write data bytes go into register 0, then 1, then 2, and each is acknowledged.
- R5: A read frame returns 0x09 first, then register 0, 1 and 2 in that order, MSB first.
- R6: Write data bytes past register 2 are acknowledged and ignored. Read bytes past register 2 return 0xFF.
- R7: Enable lines 0..5 follow register 0 bits {7,6,3,2,1,0} as {5,4,3,2,1,0}. Lines 6..11 follow register 1 bits {1,0,7,6,5,4} as {7,6,11,10,9,8}. Line 12 follows register 2 bit 6. A 1 means enabled.
- R8: Register 0 bits 5:4, register 1 bits 3:2 and register 2 bits 7 and 5:0 hold written values and read back. They do not affect any enable line.
- R9: When the controller does not acknowledge a read byte, SDA is released and stays released for the rest of the frame.
- R10: A START or STOP at any point ends the current frame. After a repeated START the sequence restarts with the address byte, then the two ignored bytes on a write, or the count byte on a read.
- R11: The block starts pulling SDA low only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level from the pad |
| sda_i | input | 1 | Serial data level from the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| clk_en_o | output | 13 | Per-output enable, 1 = enabled |

## Verification
The hardest states to reach are the aborts: a repeated START inside a read, while the block is shifting out a data byte, and a controller NACK in the middle of a read. A repeated START in a read is only possible when the bit the block is driving is a 1. So the bench first loads register 0 with its MSB set, reads the count byte with an acknowledge, and then issues the repeated START. The NACK case is made visible by loading register 0 with 0x00. After a NACK on the count byte, a released line reads back as 0xFF on the next byte. A block that kept driving would produce zeros.

// File: rtl/fan_i2c_pkg.sv
package fan_i2c_pkg;
  localparam int NOUT = 13;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKO, ST_TX, ST_ACKI
  } eng_st_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_f
);
  localparam int CW = $clog2(FILT + 1);
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // two-flop synchroniser, then the level must differ for FILT cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_f <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_f) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT - 1)) begin
        line_f <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import fan_i2c_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter logic [7:0] CNT_VAL  = 8'h09,
  parameter int         IW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          drive_low,
  output logic          busy,
  output logic          start_det,
  output logic          stop_det,
  output logic          nack_det
);
  eng_st_e       st;
  logic          scl_q, sda_q;
  logic [7:0]    shreg;
  logic [3:0]    bitcnt;
  logic          is_addr, is_read;
  logic [IW-1:0] bidx;
  logic          scl_rise, scl_fall;
  logic [7:0]    tx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  // byte 0 of a read frame is the count value, then registers from 0
  assign rd_idx  = bidx - IW'(1);
  assign tx_byte = (bidx == '0) ? CNT_VAL : rd_data;

  // the first two write bytes (command, count) never reach the bank
  assign wr_en    = (st == ST_RX) && scl_fall && (bitcnt == 4'd8) &&
                    !is_addr && (bidx >= IW'(2));
  assign wr_idx   = bidx - IW'(2);
  assign wr_data  = shreg;
  assign nack_det = (st == ST_ACKI) && scl_rise && sda_f;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      is_addr   <= 1'b0;
      is_read   <= 1'b0;
      bidx      <= '0;
      drive_low <= 1'b0;
    end else if (start_det) begin
      st        <= ST_RX;
      bitcnt    <= '0;
      is_addr   <= 1'b1;
      is_read   <= 1'b0;
      bidx      <= '0;
      drive_low <= 1'b0;
    end else if (stop_det) begin
      st        <= ST_IDLE;
      drive_low <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (is_addr && shreg[7:1] != SLV_ADDR) begin
              st <= ST_IDLE;
            end else begin
              if (is_addr) is_read <= shreg[0];
              drive_low <= 1'b1;
              st        <= ST_ACKO;
            end
          end
        end
        ST_ACKO: begin
          if (scl_fall) begin
            drive_low <= 1'b0;
            if (is_addr) is_addr <= 1'b0;
            else if (bidx != '1) bidx <= bidx + IW'(1);
            if (is_read) begin
              shreg     <= tx_byte;
              drive_low <= ~tx_byte[7];
              bitcnt    <= 4'd1;
              st        <= ST_TX;
            end else begin
              bitcnt <= '0;
              st     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              drive_low <= 1'b0;
              st        <= ST_ACKI;
            end else begin
              shreg     <= {shreg[6:0], 1'b0};
              drive_low <= ~shreg[6];
              bitcnt    <= bitcnt + 4'd1;
            end
          end
        end
        ST_ACKI: begin
          if (scl_rise) begin
            if (sda_f) st <= ST_IDLE;
            else if (bidx != '1) bidx <= bidx + IW'(1);
          end else if (scl_fall) begin
            shreg     <= tx_byte;
            drive_low <= ~tx_byte[7];
            bitcnt    <= 4'd1;
            st        <= ST_TX;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/en_reg_bank.sv
module en_reg_bank
  import fan_i2c_pkg::*;
#(
  parameter int NREG = 3,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [NOUT-1:0] en_o
);
  logic [7:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q[i] <= 8'hFF;
      else if (wr_en && wr_idx == IW'(i))     q[i] <= wr_data;
    end
  end

  // indexes past the bank read as all ones
  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IW'(i)) rd_data = q[i];
  end

  // reserved bits are stored but routed nowhere
  assign en_o = {q[2][6], q[1][7:4], q[1][1:0], q[0][7:6], q[0][3:0]};
endmodule

// File: rtl/fanout_en_i2c_slave.sv
module fanout_en_i2c_slave
  import fan_i2c_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter logic [7:0] CNT_VAL  = 8'h09,
  parameter int         NREG     = 3,
  parameter int         FILT     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_o,
  output logic [NOUT-1:0] clk_en_o
);
  localparam int IW = 4;

  logic [1:0]    raw, filt;
  logic          scl_f, sda_f;
  logic [IW-1:0] rd_idx, wr_idx;
  logic [7:0]    rd_data, wr_data;
  logic          wr_en, busy, start_det, stop_det, nack_det;

  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_cond #(.FILT(FILT)) u_cond (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]), .line_f(filt[g])
    );
  end
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  i2c_byte_engine #(.SLV_ADDR(SLV_ADDR), .CNT_VAL(CNT_VAL), .IW(IW)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .drive_low(sda_pull_o), .busy(busy),
    .start_det(start_det), .stop_det(stop_det), .nack_det(nack_det)
  );

  en_reg_bank #(.NREG(NREG), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .en_o(clk_en_o)
  );
endmodule

// File: rtl/fan_i2c_chk.sv
module fan_i2c_chk #(
  parameter int NO = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          sda_oe,
  input logic          busy,
  input logic          start_det,
  input logic          stop_det,
  input logic          nack,
  input logic          wr_en,
  input logic [NO-1:0] out_en
);
  // R11
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy && !sda_oe);
  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack |=> !busy && !sda_oe);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);
  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(out_en));
endmodule

bind fanout_en_i2c_slave fan_i2c_chk #(.NO(fan_i2c_pkg::NOUT)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_pull_o),
  .busy(busy), .start_det(start_det), .stop_det(stop_det),
  .nack(nack_det), .wr_en(wr_en), .out_en(clk_en_o)
);

// File: tb/test_fanout_en_i2c_slave.sv
module test_fanout_en_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WD_LIMIT   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_pull;
  logic        sda_bus;
  logic [12:0] clk_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] e [3];
  logic [7:0] wbuf [8];
  logic [7:0] rb [5];
  logic       ackb;

  assign sda_bus = sda_m & ~sda_pull;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fanout_en_i2c_slave i_fanout_en_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .clk_en_o(clk_en)
  );

  function automatic logic [12:0] exp_en(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    return {b2[6], b1[7:4], b1[1:0], b0[7:6], b0[3:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    acked = ~sda_bus; wq(Q);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_bus; wq(Q);
      scl_m = 1'b0;
    end
    sda_m = nack; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(1);
  endtask

  // write frame: address, command, count, then n data bytes
  task automatic do_write(int n);
    bus_start();
    send_byte(8'hD2, ackb);  chk("R2 write address ack", ackb, 1);
    send_byte(8'hA5, ackb);  chk("R3 command ack", ackb, 1);
    send_byte(8'h5A, ackb);  chk("R3 count ack", ackb, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ackb);
      chk(i < 3 ? "R4 data ack" : "R6 extra data ack", ackb, 1);
      if (i < 3) e[i] = wbuf[i];
    end
    bus_stop();
  endtask

  task automatic do_read();
    bus_start();
    send_byte(8'hD3, ackb);  chk("R2 read address ack", ackb, 1);
    for (int i = 0; i < 5; i++) recv_byte(i == 4, rb[i]);
    bus_stop();
    chk("R5 count byte", rb[0], 8'h09);
    for (int i = 0; i < 3; i++) chk("R5 register byte", rb[i + 1], e[i]);
    chk("R6 read past end", rb[4], 8'hFF);
    chk("R7 enable decode", clk_en, exp_en(e[0], e[1], e[2]));
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    logic [12:0] en_before;
    for (int i = 0; i < 3; i++) e[i] = 8'hFF;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    // R1 reset state
    chk("R1 enables after reset", clk_en, 13'h1FFF);
    chk("R1 sda released", sda_pull, 0);
    do_read();

    // R3 command and count only
    do_write(0);
    chk("R3 no change", clk_en, 13'h1FFF);
    do_read();

    // R4 R7 sweep of register values
    for (int k = 0; k < 16; k++) begin
      v = 8'(k * 17);
      wbuf[0] = v; wbuf[1] = ~v; wbuf[2] = v ^ 8'h5A;
      do_write(3);
      do_read();
    end

    // R8 reserved bits flip, enables must not move
    en_before = clk_en;
    wbuf[0] = e[0] ^ 8'h30; wbuf[1] = e[1] ^ 8'h0C; wbuf[2] = e[2] ^ 8'hBF;
    do_write(3);
    chk("R8 reserved bits no effect", clk_en, en_before);
    do_read();

    // R6 extra write bytes
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
    wbuf[3] = 8'h00; wbuf[4] = 8'h00;
    do_write(5);
    do_read();

    // R2 foreign address
    bus_start();
    send_byte(8'hA4, ackb); chk("R2 foreign address no ack", ackb, 0);
    for (int i = 0; i < 4; i++) send_byte(8'h00, ackb);
    bus_stop();
    do_read();

    // R9 controller NACK: register 0 zero, line must read ones afterwards
    wbuf[0] = 8'h00; wbuf[1] = 8'h81; wbuf[2] = 8'hFF;
    do_write(3);
    bus_start();
    send_byte(8'hD3, ackb);
    recv_byte(1'b1, rb[0]);
    chk("R9 count before nack", rb[0], 8'h09);
    recv_byte(1'b1, rb[1]);
    chk("R9 released after nack", rb[1], 8'hFF);
    chk("R9 pull off", sda_pull, 0);
    bus_stop();

    // R10 repeated start inside a write
    wbuf[0] = 8'hC3;
    do_write(1);
    bus_start();
    send_byte(8'hD2, ackb);
    send_byte(8'h77, ackb);
    bus_start();
    send_byte(8'hD2, ackb); chk("R10 address after restart", ackb, 1);
    send_byte(8'h11, ackb);
    send_byte(8'h22, ackb);
    send_byte(8'h3C, ackb);
    bus_stop();
    e[0] = 8'h3C;
    chk("R10 restart write target", clk_en, exp_en(e[0], e[1], e[2]));

    // R10 repeated start inside a read (register 0 MSB set)
    wbuf[0] = 8'hC3;
    do_write(1);
    bus_start();
    send_byte(8'hD3, ackb);
    recv_byte(1'b0, rb[0]);
    bus_start();
    send_byte(8'hD3, ackb); chk("R10 read address after restart", ackb, 1);
    recv_byte(1'b0, rb[0]);
    recv_byte(1'b1, rb[1]);
    bus_stop();
    chk("R10 count first after restart", rb[0], 8'h09);
    chk("R10 register 0 after restart", rb[1], 8'hC3);
    do_read();

    report();
  end
endmodule